// File: doc/BRIEF.md
# Comparator-Code to Residue Decoder

This block turns the outputs of a bank of threshold comparators, one comparator per interferometer channel, into a modular residue. Each time slot brings one bit from every channel. As the sensed phase moves once around the circle, the K bits step through a circular code of 2K words. Each step sets one more low-order bit until all bits are one. The next steps then clear the low-order bits one at a time, so neighbouring intervals always differ in a single bit. The block finds the interval that the current word names and reports the residue that the interval stands for.

The modulus is supplied at run time and may be any value from 1 up to twice the number of channels in use. When the modulus is smaller than the number of intervals, neighbouring intervals share a residue. An enable mask can also remove channels. The remaining channels, taken in ascending index order, then form a shorter circular code with fewer intervals. This lets a single comparator bank serve several moduli. A word that belongs to no interval is reported as an error. A configuration whose modulus does not fit the enabled channels is also reported as an error. In both cases the last good residue stays on the output. A result is produced one clock after each strobe.

Top module: `phase_residue_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears residue_o to 0 and holds valid_o and err_o low.
- R2: A strobe sampled at one clock edge yields exactly one of valid_o or err_o for the following cycle only. Without a strobe, both flags are low and residue_o is unchanged.
- R3: With all K channels enabled and mod_i = 2K, the word for interval j is defined in two halves. For 0 ≤ j ≤ K, bits 0..j−1 are one and the rest are zero. For K < j < 2K, bits 0..j−K−1 are zero and the rest are one. The reported residue is j.
- R4: With E enabled channels and 1 ≤ mod_i < 2E, interval j (0 ≤ j < 2E) reports residue floor(j·mod_i / (2E)). Every residue from 0 to mod_i−1 is therefore produced, and some are shared by two intervals.
- R5: Bits on channels whose chan_en_i bit is zero have no effect. The enabled channels, in ascending index order, act as bits 0..E−1 of a circular code of length E, as defined in R3.
- R6: A strobed word that matches no interval of the active code gives err_o high, valid_o low and an unchanged residue_o.
- R7: If mod_i is 0 or exceeds twice the number of enabled channels, every strobe gives err_o high and residue_o is unchanged.
- R8: valid_o and err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Marks a time slot whose comparator word is to be decoded |
| code_i | input | K | Comparator bits, one per channel |
| chan_en_i | input | K | Channel enable mask, 1 = channel takes part in the code |
| mod_i | input | $clog2(2K+1) | Modulus for the current slot |
| residue_o | output | $clog2(2K) | Last successfully decoded residue |
| valid_o | output | 1 | One-cycle pulse: residue_o was updated by the previous strobe |
| err_o | output | 1 | One-cycle pulse: the previous strobe carried an invalid word or configuration |

## Verification
The hardest cases to reach are those where a masked channel carries a bit that would be illegal if the channel were enabled, and an invalid word arriving straight after a valid one, where only the unchanged residue shows that the error path was taken. The stimulus covers both by sweeping every one of the 2^K input words under each mask and modulus setting, with a quiet cycle after each strobe. This drives every disabled channel to both values, puts error slots next to good ones, and includes masks and moduli that leave the configuration illegal.

// File: rtl/phdec_pkg.sv
// Package: shared types for the comparator-code to residue decoder.
// Assumes nothing beyond IEEE 1800-2017.
package phdec_pkg;
    // Outcome of the most recent time slot.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_GOOD = 2'd1,
        SLOT_BAD  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/phdec_gather.sv
// Module: phdec_gather
// Gathers the enabled comparator bits into the low end of a vector,
// keeping ascending channel order. It also counts the enabled channels.
// Assumes: the mask is stable for the slot being decoded.
module phdec_gather #(
    parameter int K = 5,
    localparam int CNT_W = $clog2(K + 1)
) (
    input  logic [K-1:0]     code_i,
    input  logic [K-1:0]     mask_i,
    output logic [K-1:0]     packed_o,
    output logic [CNT_W-1:0] count_o
);
    // Walk the channels in order and append each enabled bit.
    always_comb begin
        int fill;
        fill     = 0;
        packed_o = '0;
        for (int i = 0; i < K; i++) begin
            if (mask_i[i]) begin
                packed_o[fill] = code_i[i];
                fill = fill + 1;
            end
        end
        count_o = CNT_W'(fill);
    end
endmodule

// File: rtl/phdec_johnson.sv
// Module: phdec_johnson
// Finds the interval index of a packed circular word of E active bits.
// Interval j fills bits from the bottom up to j for j <= E, then empties
// them from the bottom. Reports whether any interval matched.
// Assumes: bits at or above E in the packed word are zero.
module phdec_johnson #(
    parameter int K = 5,
    localparam int CNT_W = $clog2(K + 1),
    localparam int IDX_W = $clog2(2 * K)
) (
    input  logic [K-1:0]     packed_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [K-1:0] ref_word;

    // Compare the input against every interval word of the active length.
    always_comb begin
        hit_o    = 1'b0;
        idx_o    = '0;
        ref_word = '0;
        for (int j = 0; j < 2 * K; j++) begin
            if (j < 2 * int'(count_i)) begin
                ref_word = '0;
                for (int b = 0; b < K; b++) begin
                    if (b < int'(count_i)) begin
                        ref_word[b] = (j <= int'(count_i)) ? (b < j)
                                                          : (b >= j - int'(count_i));
                    end
                end
                if (!hit_o && ref_word == packed_i) begin
                    hit_o = 1'b1;
                    idx_o = IDX_W'(j);
                end
            end
        end
    end
endmodule

// File: rtl/phdec_fold.sv
// Module: phdec_fold
// Folds an interval index onto a residue of the chosen modulus:
// residue = floor(idx * mod / (2E)). It uses a compare ladder, not a divider.
// It also decides whether the modulus fits the E enabled channels.
module phdec_fold #(
    parameter int K = 5,
    localparam int CNT_W = $clog2(K + 1),
    localparam int IDX_W = $clog2(2 * K),
    localparam int MOD_W = $clog2(2 * K + 1),
    localparam int RES_W = $clog2(2 * K)
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic             legal_o,
    output logic [RES_W-1:0] res_o
);
    // Configuration check: 1 <= mod <= 2E.
    always_comb begin
        legal_o = (mod_i != '0) && (int'(mod_i) <= 2 * int'(count_i));
    end

    // Largest t < mod with t * 2E <= idx * mod.
    always_comb begin
        int best;
        best = 0;
        for (int t = 1; t < 2 * K; t++) begin
            if (t < int'(mod_i) &&
                t * 2 * int'(count_i) <= int'(idx_i) * int'(mod_i)) begin
                best = t;
            end
        end
        res_o = RES_W'(best);
    end
endmodule

// File: rtl/phase_residue_decoder.sv
// Module: phase_residue_decoder (top)
// Decodes K comparator bits into a residue of a run-time modulus. Disabled
// channels are dropped from the circular code. The result is registered one
// cycle after the strobe. Invalid words or configurations raise err_o and
// keep the last residue.
// Assumes: synchronous active-low reset; inputs stable around the edge.
module phase_residue_decoder #(
    parameter int K = 5,
    localparam int CNT_W = $clog2(K + 1),
    localparam int IDX_W = $clog2(2 * K),
    localparam int MOD_W = $clog2(2 * K + 1),
    localparam int RES_W = $clog2(2 * K)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [K-1:0]     code_i,
    input  logic [K-1:0]     chan_en_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic [RES_W-1:0] residue_o,
    output logic             valid_o,
    output logic             err_o
);
    import phdec_pkg::*;

    logic [K-1:0]     packed_w;
    logic [CNT_W-1:0] count_w;
    logic             hit_w;
    logic [IDX_W-1:0] idx_w;
    logic             legal_w;
    logic [RES_W-1:0] res_w;
    slot_state_e      slot_q;
    logic [RES_W-1:0] residue_q;

    phdec_gather #(.K(K)) u_gather (
        .code_i   (code_i),
        .mask_i   (chan_en_i),
        .packed_o (packed_w),
        .count_o  (count_w)
    );

    phdec_johnson #(.K(K)) u_johnson (
        .packed_i (packed_w),
        .count_i  (count_w),
        .hit_o    (hit_w),
        .idx_o    (idx_w)
    );

    phdec_fold #(.K(K)) u_fold (
        .idx_i   (idx_w),
        .count_i (count_w),
        .mod_i   (mod_i),
        .legal_o (legal_w),
        .res_o   (res_w)
    );

    // Capture the slot outcome and update the residue only on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= SLOT_IDLE;
            residue_q <= '0;
        end else if (strobe_i) begin
            if (legal_w && hit_w) begin
                slot_q    <= SLOT_GOOD;
                residue_q <= res_w;
            end else begin
                slot_q    <= SLOT_BAD;
            end
        end else begin
            slot_q <= SLOT_IDLE;
        end
    end

    // Drive the flags from the registered slot outcome.
    always_comb begin
        residue_o = residue_q;
        valid_o   = (slot_q == SLOT_GOOD);
        err_o     = (slot_q == SLOT_BAD);
    end
endmodule

// File: rtl/phdec_checker.sv
// Module: phdec_checker
// Temporal checks on the decoder's ports, attached through bind.
module phdec_checker #(
    parameter int K = 5,
    localparam int MOD_W = $clog2(2 * K + 1),
    localparam int RES_W = $clog2(2 * K)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_i,
    input logic [MOD_W-1:0] mod_i,
    input logic [RES_W-1:0] residue_o,
    input logic             valid_o,
    input logic             err_o
);
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    a_r2_strobe_gives_flag: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (valid_o || err_o));

    a_r2_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> (!valid_o && !err_o));

    a_r6_error_holds_residue: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(residue_o));

    a_r2_residue_held_unless_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(residue_o));

    a_r4_residue_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (!valid_o || int'(residue_o) < int'($past(mod_i))));
endmodule

bind phase_residue_decoder phdec_checker #(.K(K)) u_phdec_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (strobe_i),
    .mod_i     (mod_i),
    .residue_o (residue_o),
    .valid_o   (valid_o),
    .err_o     (err_o)
);

// File: tb/phase_residue_decoder_test.sv
module phase_residue_decoder_test;
    localparam int K     = 5;
    localparam int MOD_W = $clog2(2 * K + 1);
    localparam int RES_W = $clog2(2 * K);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe_i = 1'b0;
    logic [K-1:0]     code_i = '0;
    logic [K-1:0]     chan_en_i = '0;
    logic [MOD_W-1:0] mod_i = '0;
    logic [RES_W-1:0] residue_o;
    logic             valid_o;
    logic             err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int exp_res = 0;
    bit exp_v   = 1'b0;
    bit exp_e   = 1'b0;

    phase_residue_decoder #(.K(K)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (strobe_i),
        .code_i    (code_i),
        .chan_en_i (chan_en_i),
        .mod_i     (mod_i),
        .residue_o (residue_o),
        .valid_o   (valid_o),
        .err_o     (err_o)
    );

    always #2 clk = ~clk;

    // Behavioural model: scatter each interval word onto the enabled
    // channels and compare; residue by integer division.
    function automatic void model(input logic [K-1:0] c, input logic [K-1:0] m,
                                  input int md, output bit legal, output bit ok,
                                  output int r);
        int e;
        e = 0;
        for (int i = 0; i < K; i++) if (m[i]) e++;
        legal = (md >= 1) && (md <= 2 * e);
        ok = 1'b0;
        r = 0;
        for (int j = 0; j < 2 * e; j++) begin
            logic [K-1:0] w;
            int pos;
            w = '0;
            pos = 0;
            for (int i = 0; i < K; i++) begin
                if (m[i]) begin
                    w[i] = (j <= e) ? (pos < j) : (pos >= j - e);
                    pos++;
                end
            end
            if ((c & m) == w) begin
                ok = 1'b1;
                r = (j * md) / (2 * e);
            end
        end
    endfunction

    task automatic compare(input string tag);
        n_tests++;
        if (valid_o !== exp_v || err_o !== exp_e || int'(residue_o) != exp_res) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b err=%0b res=%0d, expected valid=%0b err=%0b res=%0d",
                     tag, valid_o, err_o, residue_o, exp_v, exp_e, exp_res);
        end
    endtask

    // Drive one slot at the falling edge, predict, check at the next falling edge.
    task automatic step(input logic [K-1:0] c, input logic [K-1:0] m,
                        input int md, input bit s);
        bit legal, ok;
        int r;
        string tag;
        code_i    = c;
        chan_en_i = m;
        mod_i     = MOD_W'(md);
        strobe_i  = s;
        model(c, m, md, legal, ok, r);
        if (!s) begin
            exp_v = 1'b0; exp_e = 1'b0; tag = "R2";
        end else if (!legal) begin
            exp_v = 1'b0; exp_e = 1'b1; tag = "R7";
        end else if (!ok) begin
            exp_v = 1'b0; exp_e = 1'b1; tag = "R6";
        end else begin
            exp_v = 1'b1; exp_e = 1'b0; exp_res = r;
            if (m != {K{1'b1}})  tag = "R5";
            else if (md < 2 * K) tag = "R4";
            else                 tag = "R3";
        end
        @(negedge clk);
        compare(tag);   // flags never both high: R8
    endtask

    task automatic sweep(input logic [K-1:0] m, input int md);
        for (int c = 0; c < (1 << K); c++) begin
            step(K'(c), m, md, 1'b1);
            step(K'(c), m, md, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        exp_v = 1'b0; exp_e = 1'b0; exp_res = 0;
        compare("R1");
        rst_n = 1'b1;
        sweep(5'b11111, 10);   // R3
        sweep(5'b11111, 9);    // R4
        sweep(5'b11101, 7);    // R5: channel 1 dropped
        sweep(5'b11111, 1);    // R4 with a single residue
        sweep(5'b00011, 4);    // R5 short code
        sweep(5'b11111, 11);   // R7 modulus too large
        sweep(5'b00011, 5);    // R7 too few channels
        sweep(5'b11111, 0);    // R7 zero modulus
        step(5'b00111, 5'b11111, 10, 1'b1);
        rst_n = 1'b0;
        exp_res = 0;
        step(5'b00000, 5'b11111, 10, 1'b0);
        exp_v = 1'b0; exp_e = 1'b0; exp_res = 0;
        compare("R1");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule